// File: doc/BRIEF.md
# Per-Scanline Sprite Evaluation Unit

This block picks the sprites that a tile-based video engine shows on the following scanline. A primary object table holds 64 sprites of four bytes each: vertical position, tile number, attribute byte and horizontal position. The unit reads that table through a one-byte read port and copies up to eight sprites that cover the current line into an eight-slot secondary table. The rest of the renderer uses the secondary table to fetch pattern data later in the line.

The work follows the dot counter of the line instead of being done in one step. The first part of the line wipes the secondary table to 0xFF, one byte on every second dot. The second part walks the primary table in index order. Two dots test each sprite's vertical range, and three more dots copy the rest of a sprite that is accepted. When a ninth sprite in range turns up, a sticky overflow flag is raised. That flag clears only at the start of the pre-render line. The unit also reports how many sprites it accepted and whether sprite 0 was among them.

Top module: `sprite_eval_unit`

## Requirements
- R1: After reset, every byte of the secondary table reads 0xFF, the found count is 0, and the sprite-0 flag and the overflow flag are both 0.
- R2: On a visible line (0..239) with rendering on, the odd dots 1..63 each write 0xFF to one secondary byte, so all 32 bytes read 0xFF once dot 64 is done.
- R3: With the size control at 0 (8-line sprites), a sprite is in range when line − Y is between 0 and 7 inclusive. Y is byte 0 of the sprite's 4-byte entry, and the entry of sprite n starts at primary address 4n.
- R4: With the size control at 1 (16-line sprites), the in-range window is line − Y from 0 to 15 inclusive.
- R5: Sprites in range are taken in ascending index order. The k-th accepted sprite fills slot k with its bytes in their primary order (Y, tile, attribute, X). Slot k byte b appears at `sec_data_o[(4k+b)*8 +: 8]`. Unused slots keep 0xFF.
- R6: `found_cnt_o` gives the number of sprites accepted on the last evaluated line, from 0 to 8.
- R7: `zero_sel_o` is 1 exactly when sprite 0 was accepted on the last evaluated line.
- R8: When a ninth in-range sprite is found, `overflow_o` goes to 1 and stays 1 across later visible lines. Exactly eight sprites in range do not set it.
- R9: `overflow_o` clears at dot 1 of line 261.
- R10: With rendering off, or on lines 240 and above, the secondary table, the count and the sprite-0 flag do not change.
- R11: The scan finishes by dot 256 even when all eight accepted sprites sit at the end of the table (indices 56..63).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; one dot is processed per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 9 | Current scanline number (0..261) |
| dot_i | input | 9 | Current dot within the line (0..340) |
| tall_i | input | 1 | Sprite size control: 0 = 8 lines, 1 = 16 lines |
| render_en_i | input | 1 | Rendering enable; evaluation runs only while it is 1 |
| pri_addr_o | output | 8 | Byte address into the primary object table |
| pri_data_i | input | 8 | Primary table byte at `pri_addr_o`, valid in the same cycle |
| sec_data_o | output | 256 | Secondary table contents, 32 bytes, byte i at bits [8i+7:8i] |
| found_cnt_o | output | 4 | Number of sprites accepted on the last evaluated line |
| zero_sel_o | output | 1 | Sprite 0 was accepted on the last evaluated line |
| overflow_o | output | 1 | Sticky sprite overflow flag |

## Verification
The bench places in-range sprites one line either side of the window edges (line − Y of 7 against 8, and 15 against 16). A design with an off-by-one compare would accept or reject the wrong sprite and would give a different slot order. It also fills exactly eight sprites, and separately nine or more. A design that raised overflow on the eighth sprite, or that kept copying past slot 7, would show a wrong flag or a corrupted slot. The bench puts all eight accepted sprites at the end of the table to catch a scan that runs too slowly to reach index 63 by dot 256. It also stops a line at dot 64 to catch a clear phase that skips bytes. It runs lines with rendering off and lines past 239 to catch a design that evaluates when it should not. Finally, it checks that overflow persists across lines and drops only at the pre-render line.

// File: rtl/spreval_pkg.sv
package spreval_pkg;

    localparam int SPR_NUM   = 64;
    localparam int SPR_BYTES = 4;
    localparam int SLOT_NUM  = 8;
    localparam int SEC_BYTES = SLOT_NUM * SPR_BYTES;
    localparam int IDX_W     = $clog2(SPR_NUM);
    localparam int BYTE_W    = $clog2(SPR_BYTES);
    localparam int PRI_AW    = IDX_W + BYTE_W;
    localparam int SEC_AW    = $clog2(SEC_BYTES);
    localparam int SLOT_W    = $clog2(SLOT_NUM);
    localparam int CNT_W     = SLOT_W + 1;
    localparam int LINE_W    = 9;
    localparam int SHORT_H   = 8;
    localparam int TALL_H    = 16;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_FETCH,
        SC_TEST,
        SC_COPY
    } scan_state_e;

    typedef struct packed {
        logic              active;
        logic              start;
        logic              clr_we;
        logic [SEC_AW-1:0] clr_idx;
        logic              scan_init;
        logic              scan_en;
        logic              pre_clr;
    } sched_t;

    typedef struct packed {
        logic              en;
        logic [SEC_AW-1:0] idx;
        logic [7:0]        data;
    } sec_wr_t;

    function automatic logic spr_in_range(input logic [LINE_W-1:0] line,
                                          input logic [7:0] ypos,
                                          input logic tall);
        logic [LINE_W:0] diff;
        logic [LINE_W:0] height;
        diff   = {1'b0, line} - {{(LINE_W - 7){1'b0}}, ypos};
        height = tall ? (LINE_W + 1)'(TALL_H) : (LINE_W + 1)'(SHORT_H);
        return !diff[LINE_W] && (diff < height);
    endfunction

endpackage

// File: rtl/spreval_sched.sv
module spreval_sched
    import spreval_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int VIS_LINES = 240,
    parameter int PRE_LINE  = 261,
    parameter int CLR_LAST  = 64,
    parameter int SCAN_LAST = 256
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic              render_en_i,
    output sched_t            sch_o
);

    localparam logic [DOT_W-1:0]  DOT_ONE   = DOT_W'(1);
    localparam logic [DOT_W-1:0]  DOT_CLR   = DOT_W'(CLR_LAST);
    localparam logic [DOT_W-1:0]  DOT_SCAN0 = DOT_W'(CLR_LAST + 1);
    localparam logic [DOT_W-1:0]  DOT_SCANN = DOT_W'(SCAN_LAST);
    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] PRE_NUM   = LINE_W'(PRE_LINE);

    logic             visible;
    logic [DOT_W-1:0] dot_m1;

    always_comb begin
        visible = render_en_i && (line_i < VIS_END);
        dot_m1  = dot_i - DOT_ONE;

        sch_o.active    = visible;
        sch_o.start     = visible && (dot_i == DOT_ONE);
        sch_o.clr_we    = visible && dot_i[0] && (dot_i < DOT_CLR);
        sch_o.clr_idx   = dot_m1[SEC_AW:1];
        sch_o.scan_init = visible && (dot_i == DOT_CLR);
        sch_o.scan_en   = visible && (dot_i >= DOT_SCAN0) && (dot_i <= DOT_SCANN);
        sch_o.pre_clr   = (line_i == PRE_NUM) && (dot_i == DOT_ONE);
    end

endmodule

// File: rtl/spreval_scan.sv
module spreval_scan
    import spreval_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sched_t            sch_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              tall_i,
    output logic [PRI_AW-1:0] pri_addr_o,
    input  logic [7:0]        pri_data_i,
    output sec_wr_t           wr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              zero_o,
    output logic              ovf_o
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SPR_NUM - 1);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(SPR_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(SLOT_NUM);

    scan_state_e       st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] k_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              zero_q;
    logic              ovf_q;
    logic [7:0]        ybuf_q;
    logic              in_rng;
    logic              full;

    always_comb begin
        in_rng     = spr_in_range(line_i, ybuf_q, tall_i);
        full       = (cnt_q == FULL_CNT);
        pri_addr_o = {idx_q, (st_q == SC_COPY) ? k_q : '0};
        wr_o.en    = sch_i.scan_en &&
                     (((st_q == SC_TEST) && in_rng && !full) || (st_q == SC_COPY));
        wr_o.idx   = {cnt_q[SLOT_W-1:0], (st_q == SC_COPY) ? k_q : '0};
        wr_o.data  = (st_q == SC_TEST) ? ybuf_q : pri_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SC_IDLE;
            idx_q  <= '0;
            k_q    <= '0;
            cnt_q  <= '0;
            zero_q <= 1'b0;
            ovf_q  <= 1'b0;
            ybuf_q <= 8'h00;
        end else begin
            if (sch_i.start) begin
                cnt_q  <= '0;
                zero_q <= 1'b0;
            end
            if (sch_i.scan_init) begin
                st_q  <= SC_FETCH;
                idx_q <= '0;
                k_q   <= '0;
            end else if (sch_i.scan_en) begin
                case (st_q)
                    SC_FETCH: begin
                        ybuf_q <= pri_data_i;
                        st_q   <= SC_TEST;
                    end
                    SC_TEST: begin
                        if (in_rng && full) begin
                            ovf_q <= 1'b1;
                            st_q  <= SC_IDLE;
                        end else if (in_rng) begin
                            if (idx_q == '0) zero_q <= 1'b1;
                            k_q  <= BYTE_W'(1);
                            st_q <= SC_COPY;
                        end else if (idx_q == LAST_IDX) begin
                            st_q <= SC_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= SC_FETCH;
                        end
                    end
                    SC_COPY: begin
                        if (k_q == LAST_BYTE) begin
                            cnt_q <= cnt_q + 1'b1;
                            k_q   <= '0;
                            if (idx_q == LAST_IDX) begin
                                st_q <= SC_IDLE;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                                st_q  <= SC_FETCH;
                            end
                        end else begin
                            k_q <= k_q + 1'b1;
                        end
                    end
                    default: st_q <= SC_IDLE;
                endcase
            end
            if (sch_i.pre_clr) ovf_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = zero_q;
    assign ovf_o  = ovf_q;

    // R6: never more than the slot count
    p_cnt_max_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

    // R7: sprite 0 accepted implies at least one sprite counted or being copied
    p_zero_copy_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_q) |-> (st_q == SC_COPY) && (idx_q == '0));

    // R8: overflow only rises once all slots are taken
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> full);

    // R9: pre-render dot 1 drops overflow
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        sch_i.pre_clr |=> !ovf_q);

    // R10: outside evaluation the results hold
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sch_i.active |=> $stable(cnt_q) && $stable(zero_q));

endmodule

// File: rtl/spreval_sec.sv
module spreval_sec
    import spreval_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_we_i,
    input  logic [SEC_AW-1:0]      clr_idx_i,
    input  sec_wr_t                wr_i,
    output logic [SEC_BYTES*8-1:0] sec_data_o
);

    logic [7:0] mem_q [SEC_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SEC_BYTES; i++) mem_q[i] <= 8'hFF;
        end else begin
            if (clr_we_i) mem_q[clr_idx_i] <= 8'hFF;
            if (wr_i.en)  mem_q[wr_i.idx]  <= wr_i.data;
        end
    end

    for (genvar g = 0; g < SEC_BYTES; g++) begin : g_flat
        assign sec_data_o[g*8 +: 8] = mem_q[g];
    end

    // R2: a clear strobe leaves its byte at 0xFF
    p_clear_ff_r2: assert property (@(posedge clk) disable iff (rst)
        clr_we_i && !wr_i.en |=> mem_q[$past(clr_idx_i)] == 8'hFF);

    // R5: a copy write lands in the addressed byte
    p_copy_lands_r5: assert property (@(posedge clk) disable iff (rst)
        wr_i.en |=> mem_q[$past(wr_i.idx)] == $past(wr_i.data));

    // R2/R5: clear and copy never collide
    p_no_collide_r2: assert property (@(posedge clk) disable iff (rst)
        !(clr_we_i && wr_i.en));

endmodule

// File: rtl/sprite_eval_unit.sv
module sprite_eval_unit
    import spreval_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int VIS_LINES = 240,
    parameter int PRE_LINE  = 261,
    parameter int CLR_LAST  = 64,
    parameter int SCAN_LAST = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LINE_W-1:0]      line_i,
    input  logic [DOT_W-1:0]       dot_i,
    input  logic                   tall_i,
    input  logic                   render_en_i,
    output logic [PRI_AW-1:0]      pri_addr_o,
    input  logic [7:0]             pri_data_i,
    output logic [SEC_BYTES*8-1:0] sec_data_o,
    output logic [CNT_W-1:0]       found_cnt_o,
    output logic                   zero_sel_o,
    output logic                   overflow_o
);

    sched_t  sch;
    sec_wr_t wr;

    spreval_sched #(
        .DOT_W    (DOT_W),
        .VIS_LINES(VIS_LINES),
        .PRE_LINE (PRE_LINE),
        .CLR_LAST (CLR_LAST),
        .SCAN_LAST(SCAN_LAST)
    ) u_sched (
        .line_i     (line_i),
        .dot_i      (dot_i),
        .render_en_i(render_en_i),
        .sch_o      (sch)
    );

    spreval_scan u_scan (
        .clk       (clk),
        .rst       (rst),
        .sch_i     (sch),
        .line_i    (line_i),
        .tall_i    (tall_i),
        .pri_addr_o(pri_addr_o),
        .pri_data_i(pri_data_i),
        .wr_o      (wr),
        .cnt_o     (found_cnt_o),
        .zero_o    (zero_sel_o),
        .ovf_o     (overflow_o)
    );

    spreval_sec u_sec (
        .clk       (clk),
        .rst       (rst),
        .clr_we_i  (sch.clr_we),
        .clr_idx_i (sch.clr_idx),
        .wr_i      (wr),
        .sec_data_o(sec_data_o)
    );

    // R1: overflow cannot be set on the cycle right after reset
    p_reset_clean_r1: assert property (@(posedge clk)
        $past(rst) |-> !overflow_o && (found_cnt_o == '0) && !zero_sel_o);

endmodule

// File: tb/tb_sprite_eval_unit.sv
module tb_sprite_eval_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [8:0]   line_i = '0;
    logic [8:0]   dot_i = '0;
    logic         tall_i = 1'b0;
    logic         render_en_i = 1'b0;
    logic [7:0]   pri_addr_o;
    logic [7:0]   pri_data_i;
    logic [255:0] sec_data_o;
    logic [3:0]   found_cnt_o;
    logic         zero_sel_o;
    logic         overflow_o;

    logic [7:0]   pmem [256];
    logic [255:0] exp_sec;
    int           exp_cnt;
    logic         exp_zero;
    logic         exp_ovf;
    int           checks = 0;
    int           fails = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    assign pri_data_i = pmem[pri_addr_o];

    sprite_eval_unit dut (
        .clk        (clk),
        .rst        (rst),
        .line_i     (line_i),
        .dot_i      (dot_i),
        .tall_i     (tall_i),
        .render_en_i(render_en_i),
        .pri_addr_o (pri_addr_o),
        .pri_data_i (pri_data_i),
        .sec_data_o (sec_data_o),
        .found_cnt_o(found_cnt_o),
        .zero_sel_o (zero_sel_o),
        .overflow_o (overflow_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(sec_data_o == exp_sec, req, "secondary table", sec_data_o, exp_sec);
        check(found_cnt_o == 4'(exp_cnt), req, "found count",
              256'(found_cnt_o), 256'(exp_cnt));
        check(zero_sel_o == exp_zero, req, "sprite0 flag",
              256'(zero_sel_o), 256'(exp_zero));
        check(overflow_o == exp_ovf, req, "overflow",
              256'(overflow_o), 256'(exp_ovf));
    endtask

    // fill table: every sprite out of range (Y=0xF0), distinct other bytes
    task automatic clear_pmem();
        for (int i = 0; i < 64; i++) begin
            pmem[i*4]     = 8'hF0;
            pmem[i*4 + 1] = 8'(i + 8'h10);
            pmem[i*4 + 2] = 8'(i) ^ 8'h5A;
            pmem[i*4 + 3] = 8'(i + 100);
        end
    endtask

    // model from R3..R8: ascending scan, first eight copied, ninth flags overflow
    task automatic build_expected(input int line, input bit tall);
        int h;
        int n;
        h = tall ? 16 : 8;
        n = 0;
        exp_sec  = '1;
        exp_zero = 1'b0;
        for (int i = 0; i < 64; i++) begin
            int diff;
            diff = line - int'(pmem[i*4]);
            if (diff >= 0 && diff < h) begin
                if (n < 8) begin
                    for (int b = 0; b < 4; b++)
                        exp_sec[(n*4 + b)*8 +: 8] = pmem[i*4 + b];
                    if (i == 0) exp_zero = 1'b1;
                    n++;
                end else if (n == 8) begin
                    exp_ovf = 1'b1;
                    n++;
                end
            end
        end
        exp_cnt = (n > 8) ? 8 : n;
    endtask

    task automatic run_dots(input int line, input int from, input int to,
                            input bit ren, input bit tall);
        for (int d = from; d <= to; d++) begin
            @(negedge clk);
            line_i      = 9'(line);
            dot_i       = 9'(d);
            render_en_i = ren;
            tall_i      = tall;
        end
        @(negedge clk);
        line_i = 9'd250;
        dot_i  = 9'd0;
    endtask

    task automatic t_reset();
        exp_sec = '1; exp_cnt = 0; exp_zero = 1'b0; exp_ovf = 1'b0;
        check_all("R1");
    endtask

    task automatic t_basic();
        clear_pmem();
        pmem[0]  = 8'd15;  // diff 5, in
        pmem[20] = 8'd20;  // diff 0, in
        pmem[28] = 8'd12;  // diff 8, out (short)
        pmem[36] = 8'd13;  // diff 7, in
        pmem[44] = 8'd21;  // diff -1, out
        build_expected(20, 1'b0);
        run_dots(20, 0, 340, 1'b1, 1'b0);
        check_all("R3 R5 R6 R7");
    endtask

    task automatic t_clear();
        run_dots(21, 0, 64, 1'b1, 1'b0);
        check(sec_data_o == '1, "R2", "all bytes wiped by dot 64", sec_data_o, '1);
        run_dots(21, 65, 340, 1'b1, 1'b0);
    endtask

    task automatic t_tall();
        clear_pmem();
        pmem[0]  = 8'd4;   // diff 16, out (tall boundary)
        pmem[8]  = 8'd5;   // diff 15, in
        pmem[28] = 8'd12;  // diff 8, in only when tall
        build_expected(20, 1'b1);
        run_dots(20, 0, 340, 1'b1, 1'b1);
        check_all("R4");
    endtask

    task automatic t_overflow();
        clear_pmem();
        for (int i = 1; i <= 10; i++) pmem[i*4] = 8'd100;
        build_expected(103, 1'b0);
        run_dots(103, 0, 340, 1'b1, 1'b0);
        check_all("R8 overflow on ninth");
        clear_pmem();
        pmem[0] = 8'd104;
        build_expected(104, 1'b0);
        run_dots(104, 0, 340, 1'b1, 1'b0);
        check_all("R8 sticky");
        run_dots(261, 0, 1, 1'b1, 1'b0);
        exp_ovf = 1'b0;
        check(overflow_o == 1'b0, "R9", "cleared at pre-render dot 1",
              256'(overflow_o), 256'(0));
    endtask

    task automatic t_late();
        clear_pmem();
        for (int i = 56; i < 64; i++) pmem[i*4] = 8'd200;
        build_expected(207, 1'b0);
        run_dots(207, 0, 340, 1'b1, 1'b0);
        check_all("R11 R8 exactly eight");
    endtask

    task automatic t_idle();
        clear_pmem();
        pmem[0] = 8'd50;
        run_dots(50, 0, 340, 1'b0, 1'b0);
        check_all("R10 render off");
        run_dots(245, 0, 340, 1'b1, 1'b0);
        check_all("R10 line past visible");
    endtask

    task automatic t_empty();
        clear_pmem();
        build_expected(30, 1'b0);
        run_dots(30, 0, 340, 1'b1, 1'b0);
        check_all("R6 empty line");
    endtask

    initial begin
        clear_pmem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_tall();
        t_overflow();
        t_late();
        t_idle();
        t_empty();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule